// File: doc/BRIEF.md
# SPI Banked Register Command Slave

This block is a mode-0 SPI target that accepts one-byte command headers and gives access to a banked file of byte-wide control registers and to a small byte buffer. A frame starts when chip-select falls and ends when it rises. The first byte of a frame selects the operation and, in most cases, a register address. The bytes that follow carry write data, or carry the clock cycles in which read data is shifted out.

The register file has four banks of 32 addresses. The top five addresses are the same physical registers in every bank. One of them holds the two bank-select bits. A read from a register that is flagged as MAC/MII class has one dummy byte in front of the data. The buffer is written and read in bursts. Each pointer steps forward once for every data byte and wraps at the end of the buffer. The SPI pins are synchronised into the system clock domain, and the current bank is brought out on a debug port.

Top module: `spi_bank_cmd_slave`

## Requirements
- R1: The header byte (byte slot 0 of a frame) holds the opcode in bits 7:5 and the register address in bits 4:0. Encodings: 000 read register, 001 read buffer, 010 write register, 011 write buffer, 100 bit set, 101 bit clear, 111 soft reset.
- R2: A write-register frame stores byte slot 1 into the addressed register of the active bank. Bytes after slot 1 have no effect.
- R3: A read-register frame to a register that is not MAC/MII class returns the register value in byte slot 1, MSB first.
- R4: A read-register frame to a MAC/MII-class register returns 0x00 in slot 1 and the register value in slot 2. By default this class covers bank 2 addresses 0x00-0x19 and bank 3 addresses 0x00-0x05 and 0x0A.
- R5: The active bank is bits 1:0 of the register at address 0x1F (bit1*2+bit0), and `bank_dbg` shows it.
- R6: Addresses 0x1B-0x1F reach the same storage from every bank.
- R7: A bit-set frame ORs byte slot 1 into the addressed register.
- R8: A bit-clear frame clears every register bit that is 1 in byte slot 1.
- R9: A soft-reset header (opcode 111, any address bits) clears bits 1:0 of register 0x1F and changes nothing else.
- R10: After a header of exactly 0x7A, every further byte of the frame is written to the buffer at the write pointer, which then advances by one and wraps from 255 to 0.
- R11: After a header of exactly 0x3A, every further byte slot returns the buffer byte at the read pointer, which then advances by one and wraps from 255 to 0. The pointer carries over from one frame to the next.
- R12: A header with opcode 110, or with a buffer opcode whose address bits differ from the values in R10 and R11, holds MISO at 0 for the whole frame. Such a frame changes no register, no buffer byte and no pointer.
- R13: MOSI is sampled on rising SCLK and MISO changes only after falling SCLK. MISO is 0 in byte slot 0 and while chip-select is high.
- R14: Synchronous reset clears all registers, both pointers, the bank and MISO to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip-select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| bank_dbg | output | 2 | Currently selected register bank |

## Verification
The assertions assume that every SCLK level lasts several system clocks, so the two-stage synchronisers see each edge, and that chip-select changes only while SCLK is low. Under those conditions MISO can move only after a detected falling edge or a chip-select change. The stimulus keeps SCLK at six system clocks per level and adds guard intervals around chip-select. It also sends only whole bytes, so the byte counters and pointers that the properties track advance once per completed byte.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;
    localparam int BANK_W        = 2;
    localparam int NUM_BANKS     = 1 << BANK_W;
    localparam int ADDR_W        = 5;
    localparam int REGS_PER_BANK = 1 << ADDR_W;
    localparam int SHARED_BASE   = 27;
    localparam int SHARED_CNT    = REGS_PER_BANK - SHARED_BASE;
    localparam int SIDX_W        = $clog2(SHARED_CNT);
    localparam int MAP_W         = NUM_BANKS * REGS_PER_BANK;

    localparam logic [7:0] RDBUF_HDR = 8'h3A;
    localparam logic [7:0] WRBUF_HDR = 8'h7A;

    typedef enum logic [2:0] {
        OP_RDREG   = 3'b000,
        OP_RDBUF   = 3'b001,
        OP_WRREG   = 3'b010,
        OP_WRBUF   = 3'b011,
        OP_SETB    = 3'b100,
        OP_CLRB    = 3'b101,
        OP_UNUSED  = 3'b110,
        OP_SOFTRST = 3'b111
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef enum logic [3:0] {
        ST_HDR,
        ST_RDREG,
        ST_RDREG_DLY,
        ST_WRREG,
        ST_SETB,
        ST_CLRB,
        ST_RDBUF,
        ST_WRBUF,
        ST_DONE,
        ST_DEAD
    } cmd_st_e;

    function automatic logic is_shared(input logic [ADDR_W-1:0] a);
        return int'(a) >= SHARED_BASE;
    endfunction

    function automatic cmd_st_e decode_hdr(input logic [7:0] b, input logic mac);
        hdr_t h;
        h = hdr_t'(b);
        case (h.op)
            OP_RDREG:   return mac ? ST_RDREG_DLY : ST_RDREG;
            OP_RDBUF:   return (b == RDBUF_HDR) ? ST_RDBUF : ST_DEAD;
            OP_WRREG:   return ST_WRREG;
            OP_WRBUF:   return (b == WRBUF_HDR) ? ST_WRBUF : ST_DEAD;
            OP_SETB:    return ST_SETB;
            OP_CLRB:    return ST_CLRB;
            OP_SOFTRST: return ST_DONE;
            default:    return ST_DEAD;
        endcase
    endfunction
endpackage

// File: rtl/spi_bank_link.sv
module spi_bank_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_next_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    output logic [1:0] rx_idx_o,
    output logic       idle_o,
    output logic       miso_o
);
    logic [1:0] sclk_sy, cs_sy, mosi_sy;
    logic       sclk_d;
    logic       sclk_s, cs_s, mosi_s, rise, fall;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic [1:0] byte_idx;
    logic [7:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy <= 2'b00;
            cs_sy   <= 2'b11;
            mosi_sy <= 2'b00;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sy <= {sclk_sy[0], sclk_i};
            cs_sy   <= {cs_sy[0], cs_n_i};
            mosi_sy <= {mosi_sy[0], mosi_i};
            sclk_d  <= sclk_sy[1];
        end
    end

    assign sclk_s = sclk_sy[1];
    assign cs_s   = cs_sy[1];
    assign mosi_s = mosi_sy[1];
    assign rise   = sclk_s & ~sclk_d;
    assign fall   = ~sclk_s & sclk_d;

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_idx   <= '0;
            tx_q       <= '0;
            rx_valid_o <= 1'b0;
            rx_byte_o  <= '0;
            rx_idx_o   <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            if (rise) begin
                shreg   <= {shreg[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid_o <= 1'b1;
                    rx_byte_o  <= {shreg, mosi_s};
                    rx_idx_o   <= byte_idx;
                    if (byte_idx != 2'd3)
                        byte_idx <= byte_idx + 2'd1;
                end
            end
            if (fall)
                tx_q <= (bit_cnt == 3'd0) ? tx_next_i : {tx_q[6:0], 1'b0};
        end
    end

    assign miso_o = tx_q[7];
    assign idle_o = cs_s;

    // R13
    miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall && !cs_s) |=> $stable(miso_o));
endmodule

// File: rtl/spi_bank_regfile.sv
module spi_bank_regfile
    import spi_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              clr_bank_i,
    output logic [7:0]        rdata_o,
    output logic [BANK_W-1:0] bank_o
);
    logic [7:0]        shr_q   [SHARED_CNT];
    logic [7:0]        bank_rd [NUM_BANKS];
    logic              shared_hit;
    logic [SIDX_W-1:0] sidx;

    assign shared_hit = is_shared(addr_i);
    assign sidx       = SIDX_W'(addr_i - ADDR_W'(SHARED_BASE));
    assign bank_o     = shr_q[SHARED_CNT-1][BANK_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [7:0] mem [SHARED_BASE];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SHARED_BASE; i++)
                    mem[i] <= '0;
            end else if (we_i && !shared_hit && bank_o == BANK_W'(b)) begin
                mem[addr_i] <= wdata_i;
            end
        end
        assign bank_rd[b] = shared_hit ? 8'h00 : mem[addr_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SHARED_CNT; i++)
                shr_q[i] <= '0;
        end else begin
            if (we_i && shared_hit)
                shr_q[sidx] <= wdata_i;
            if (clr_bank_i)
                shr_q[SHARED_CNT-1][BANK_W-1:0] <= '0;
        end
    end

    assign rdata_o = shared_hit ? shr_q[sidx] : bank_rd[bank_o];

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_i && !clr_bank_i) |=> $stable(bank_o));
    // R9
    softrst_bank_chk: assert property (@(posedge clk) disable iff (rst)
        clr_bank_i |=> (bank_o == '0));
endmodule

// File: rtl/spi_bank_buffer.sv
module spi_bank_buffer #(
    parameter int AW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_adv_i,
    output logic [7:0] rd_cur_o,
    output logic [7:0] rd_nxt_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en_i)
            mem[wr_ptr] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en_i)
                wr_ptr <= wr_ptr + AW'(1);
            if (rd_adv_i)
                rd_ptr <= rd_ptr + AW'(1);
        end
    end

    assign rd_cur_o = mem[rd_ptr];
    assign rd_nxt_o = mem[rd_ptr + AW'(1)];

    // R10
    wrptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (wr_ptr == $past(wr_ptr) + AW'(1)));
    // R11
    rdptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        rd_adv_i |=> (rd_ptr == $past(rd_ptr) + AW'(1)));
    // R12
    wrptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(wr_ptr));
endmodule

// File: rtl/spi_bank_cmd_slave.sv
module spi_bank_cmd_slave
    import spi_bank_pkg::*;
#(
    parameter int               BUF_AW  = 8,
    parameter logic [MAP_W-1:0] MAC_MAP = 128'h0000043F_03FFFFFF_00000000_00000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [BANK_W-1:0] bank_dbg
);
    logic              rx_valid, idle;
    logic [7:0]        rx_byte;
    logic [1:0]        rx_idx;
    hdr_t              hdr_in;
    cmd_st_e           st_q, nxt_st;
    logic [ADDR_W-1:0] addr_q, rf_addr;
    logic [7:0]        tx_next_q, rf_rdata, rf_wdata, buf_cur, buf_nxt;
    logic              rf_we, clr_bank, buf_we, buf_adv, mac_hit;
    logic              hdr_evt, arg_evt, dat_evt;

    spi_bank_link u_link (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .mosi_i     (mosi),
        .tx_next_i  (tx_next_q),
        .rx_valid_o (rx_valid),
        .rx_byte_o  (rx_byte),
        .rx_idx_o   (rx_idx),
        .idle_o     (idle),
        .miso_o     (miso)
    );

    spi_bank_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (rf_we),
        .addr_i     (rf_addr),
        .wdata_i    (rf_wdata),
        .clr_bank_i (clr_bank),
        .rdata_o    (rf_rdata),
        .bank_o     (bank_dbg)
    );

    spi_bank_buffer #(.AW(BUF_AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (buf_we),
        .wr_data_i (rx_byte),
        .rd_adv_i  (buf_adv),
        .rd_cur_o  (buf_cur),
        .rd_nxt_o  (buf_nxt)
    );

    assign hdr_in  = hdr_t'(rx_byte);
    assign hdr_evt = rx_valid && (rx_idx == 2'd0);
    assign arg_evt = rx_valid && (rx_idx == 2'd1);
    assign dat_evt = rx_valid && (rx_idx != 2'd0);
    assign rf_addr = hdr_evt ? hdr_in.addr : addr_q;
    assign mac_hit = MAC_MAP[{bank_dbg, hdr_in.addr}];

    always_comb begin
        nxt_st   = decode_hdr(rx_byte, mac_hit);
        rf_we    = arg_evt && (st_q inside {ST_WRREG, ST_SETB, ST_CLRB});
        clr_bank = hdr_evt && (hdr_in.op == OP_SOFTRST);
        buf_we   = dat_evt && (st_q == ST_WRBUF);
        buf_adv  = dat_evt && (st_q == ST_RDBUF);
        case (st_q)
            ST_SETB: rf_wdata = rf_rdata | rx_byte;
            ST_CLRB: rf_wdata = rf_rdata & ~rx_byte;
            default: rf_wdata = rx_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || idle) begin
            st_q      <= ST_HDR;
            addr_q    <= '0;
            tx_next_q <= '0;
        end else if (rx_valid) begin
            if (rx_idx == 2'd0) begin
                st_q   <= nxt_st;
                addr_q <= hdr_in.addr;
                case (nxt_st)
                    ST_RDREG: tx_next_q <= rf_rdata;
                    ST_RDBUF: tx_next_q <= buf_cur;
                    default:  tx_next_q <= 8'h00;
                endcase
            end else begin
                if (st_q == ST_RDREG_DLY && rx_idx == 2'd1)
                    tx_next_q <= rf_rdata;
                else if (st_q == ST_RDBUF)
                    tx_next_q <= buf_nxt;
                else
                    tx_next_q <= 8'h00;
            end
        end
    end

    // R12
    dead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DEAD) |-> (!rf_we && !buf_we && !buf_adv && !clr_bank && tx_next_q == 8'h00));
endmodule

// File: tb/spi_bank_cmd_slave_tb.sv
module spi_bank_cmd_slave_tb;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [1:0] bank_dbg;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] tx_b  [0:299];
    logic [7:0] rx_b  [0:299];
    logic [7:0] m_reg [0:159];
    logic [7:0] m_buf [0:255];
    int m_wp = 0;
    int m_rp = 0;

    always #10 clk = ~clk;

    spi_bank_cmd_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .miso     (miso),
        .bank_dbg (bank_dbg)
    );

    function automatic int ridx(int b, int a);
        return (a >= 27) ? 128 + a : b * 32 + a;
    endfunction

    function automatic bit is_mac(int b, int a);
        return (b == 2 && a <= 25) || (b == 3 && (a <= 5 || a == 10));
    endfunction

    function automatic int m_bank();
        return int'(m_reg[ridx(0, 31)][1:0]);
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int n);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [7:0] r;
            r = 8'h00;
            for (int k = 7; k >= 0; k--) begin
                mosi = tx_b[i][k];
                repeat (HALF) @(negedge clk);
                r[k] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
            rx_b[i] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_reg(input logic [2:0] op, input int a, input logic [7:0] d, input bit extra);
        int i;
        tx_b[0] = {op, 5'(a)};
        tx_b[1] = d;
        tx_b[2] = 8'hFF;
        run_frame(extra ? 3 : 2);
        i = ridx(m_bank(), a);
        case (op)
            3'b010:  m_reg[i] = d;
            3'b100:  m_reg[i] = m_reg[i] | d;
            3'b101:  m_reg[i] = m_reg[i] & ~d;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input int a, input string tag);
        bit mac;
        logic [7:0] exp;
        mac = is_mac(m_bank(), a);
        exp = m_reg[ridx(m_bank(), a)];
        tx_b[0] = {3'b000, 5'(a)};
        tx_b[1] = 8'h00;
        tx_b[2] = 8'h00;
        run_frame(mac ? 3 : 2);
        check8(rx_b[0], 8'h00, "R13 slot0");
        if (mac) begin
            check8(rx_b[1], 8'h00, "R4 dummy");
            check8(rx_b[2], exp, tag);
        end else begin
            check8(rx_b[1], exp, tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 160; i++) m_reg[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R14 reset state
        check8({7'd0, miso}, 8'h00, "R14 miso");
        check8({6'd0, bank_dbg}, 8'h00, "R14 bank");
        rd_reg(0, "R14");
        rd_reg(31, "R14");

        // R1 R2: write sweep over every bank and address
        for (int b = 0; b < 4; b++) begin
            do_reg(3'b010, 31, 8'hA0 | 8'(b), 1'b0);
            check8({6'd0, bank_dbg}, 8'(b), "R5 bank");
            for (int a = 0; a < 31; a++)
                do_reg(3'b010, a, 8'((b * 37 + a * 5 + 1) & 255), a == 3);
        end

        // R3 R4 R6: read sweep
        for (int b = 0; b < 4; b++) begin
            do_reg(3'b010, 31, 8'hA0 | 8'(b), 1'b0);
            for (int a = 0; a < 32; a++)
                rd_reg(a, (a >= 27) ? "R6" : (is_mac(b, a) ? "R1 R4" : "R1 R2 R3"));
        end

        // R7 R8 bit operations
        do_reg(3'b010, 31, 8'hA1, 1'b0);
        do_reg(3'b100, 4, 8'h0F, 1'b0);
        rd_reg(4, "R7");
        do_reg(3'b101, 4, 8'h3C, 1'b0);
        rd_reg(4, "R8");
        do_reg(3'b100, 31, 8'h02, 1'b0);
        check8({6'd0, bank_dbg}, 8'd3, "R7 bank");
        do_reg(3'b101, 31, 8'h01, 1'b0);
        check8({6'd0, bank_dbg}, 8'd2, "R8 bank");

        // R9 soft reset with nonzero address bits
        tx_b[0] = 8'hE5;
        run_frame(1);
        m_reg[ridx(0, 31)] = m_reg[ridx(0, 31)] & 8'hFC;
        check8({6'd0, bank_dbg}, 8'd0, "R9 bank");
        rd_reg(31, "R9");
        rd_reg(5, "R9");

        // R12 invalid headers
        tx_b[0] = 8'hC3; tx_b[1] = 8'h55; tx_b[2] = 8'h55;
        run_frame(3);
        for (int i = 0; i < 3; i++) check8(rx_b[i], 8'h00, "R12 miso");
        rd_reg(3, "R12");
        tx_b[0] = 8'h3B; tx_b[1] = 8'h00; tx_b[2] = 8'h00;
        run_frame(3);
        for (int i = 0; i < 3; i++) check8(rx_b[i], 8'h00, "R12 miso");
        tx_b[0] = 8'h7B; tx_b[1] = 8'h11; tx_b[2] = 8'h22;
        run_frame(3);
        check8({7'd0, miso}, 8'h00, "R13 idle");

        // R10 buffer write, full sweep then wrap
        tx_b[0] = 8'h7A;
        for (int i = 0; i < 256; i++) tx_b[1 + i] = 8'((i * 7 + 3) & 255);
        run_frame(257);
        for (int i = 0; i < 256; i++) begin
            m_buf[m_wp] = tx_b[1 + i];
            m_wp = (m_wp + 1) % 256;
        end
        check8(rx_b[1], 8'h00, "R13 write slot");
        tx_b[0] = 8'h7A; tx_b[1] = 8'h5A;
        run_frame(2);
        m_buf[m_wp] = 8'h5A;
        m_wp = (m_wp + 1) % 256;

        // R11 buffer read with wrap, then continuation
        tx_b[0] = 8'h3A;
        for (int i = 1; i < 258; i++) tx_b[i] = 8'h00;
        run_frame(258);
        check8(rx_b[0], 8'h00, "R13 slot0");
        for (int i = 1; i < 258; i++) begin
            check8(rx_b[i], m_buf[m_rp], "R10 R11 R12");
            m_rp = (m_rp + 1) % 256;
        end
        run_frame(2);
        check8(rx_b[1], m_buf[m_rp], "R11 continue");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule